// File: doc/BRIEF.md
# DDR Refresh Scheduler with Postponement and Self Refresh Sequencing

This block sits on the controller side of a DDR SDRAM interface and decides when a refresh is due. A tick generator turns the clock frequency, given as a parameter in kHz, into the number of cycles in one average refresh interval of 7.8125 us. Each tick adds one to a debt counter. The main command scheduler watches a request flag. It can put refreshes off while it is busy with traffic, and it reports each refresh it actually puts on the bus with a one-cycle issued pulse. Up to eight refreshes can be owed. When the debt reaches eight the urgent flag rises, and the scheduler must not defer any longer. This bounds the gap between two refresh commands to nine intervals.

The block also times everything a refresh or a self refresh involves. After an accepted refresh a busy window of tRFC cycles blocks new commands and holds the clock enable high. A self refresh request drops the clock enable and freezes the interval timer. An exit request waits until the clock is reported stable, then raises the clock enable. It then holds the command bus to NOPs for tXSNR cycles and keeps reads locked until a 200-cycle DLL relock count has also run out. The debt is cleared on exit because the device refreshed itself while it slept.

Top module: `ddr_refresh_sched`

## Requirements
- R1: After reset: debt 0, ref_req 0, ref_urgent 0, ref_busy 0, cmd_block 0, cke 1 and read_allowed 1.
- R2: The refresh interval is CLK_KHZ*78125/10000000 cycles. With the timer running, the first debt increment is visible one cycle after the interval's last cycle, that is after the INTERVAL-th rising edge following reset release, and then every INTERVAL cycles.
- R3: ref_req is 1 exactly when debt is non-zero and the block is idle (not busy, not in self refresh, not in the tXSNR window).
- R4: Debt saturates at MAX_DEBT (8). ref_urgent is 1 exactly when debt equals MAX_DEBT.
- R5: A ref_issued pulse while ref_req is 1 lowers debt by one (unless a tick lands in the same cycle). It also raises ref_busy and cmd_block for exactly TRFC_CYC cycles starting the next cycle, with cke held at 1.
- R6: A ref_issued pulse while ref_req is 0 (debt 0 or busy) is ignored: debt and ref_busy are unchanged.
- R7: An sr_enter pulse while idle drives cke to 0, read_allowed to 0 and cmd_block to 1 from the next cycle. It also stops the interval ticks, so debt does not grow during self refresh.
- R8: While in self refresh, sr_exit is honoured only when clk_stable is 1. Otherwise cke stays 0.
- R9: On an accepted exit, cke returns to 1 and debt reads 0 from the next cycle, and cmd_block stays 1 for exactly TXSNR_CYC cycles.
- R10: read_allowed returns to 1 exactly DLL_CYC cycles after the exit edge, given DLL_CYC >= TXSNR_CYC.
- R11: If ref_issued (with ref_req 1) and sr_enter arrive in the same cycle, the refresh wins: ref_busy rises, cke stays 1 and sr_enter is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_issued | input | 1 | Scheduler put a refresh command on the bus this cycle |
| sr_enter | input | 1 | Request to enter self refresh |
| sr_exit | input | 1 | Request to leave self refresh |
| clk_stable | input | 1 | Memory clock is stable, so exit may proceed |
| ref_req | output | 1 | A refresh is owed and may be issued |
| ref_urgent | output | 1 | Debt at its ceiling, refresh must not be deferred |
| ref_busy | output | 1 | Inside the tRFC window of an accepted refresh |
| cmd_block | output | 1 | Only NOP may be issued (tRFC, self refresh, tXSNR) |
| cke | output | 1 | Clock enable to the memory |
| read_allowed | output | 1 | READ commands are permitted |
| debt | output | DW | Number of refreshes currently owed |

## Verification
All outputs are registered, so a pulse driven before rising edge E shows its effect on the outputs after E. The bench drives on the falling edge and samples one falling edge later. Timed results count in edges from the accepting edge: busy ends after edge E+TRFC_CYC, cmd_block after X+TXSNR_CYC and the read lock after X+DLL_CYC, where X is the exit edge. The first debt increment comes after edge INTERVAL from reset release. For each window the bench checks the cycle just before the expected change and the cycle of the change, so an off-by-one in either direction is reported.

// File: rtl/ddr_ref_pkg.sv
package ddr_ref_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RFC  = 2'd1,
    ST_SR   = 2'd2,
    ST_XSNR = 2'd3
  } seq_state_e;

  // average refresh interval of 7.8125 us expressed in clock cycles
  function automatic int unsigned refi_cycles(input int unsigned clk_khz);
    longint unsigned prod;
    prod = longint'(clk_khz) * 64'd78125;
    return int'(prod / 64'd10000000);
  endfunction

endpackage

// File: rtl/refi_tick_gen.sv
module refi_tick_gen #(
  parameter int unsigned INTERVAL = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)             cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);

  // R2: after a tick the interval restarts from zero
  assert_tick_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

endmodule

// File: rtl/refresh_debt_ctr.sv
module refresh_debt_ctr #(
  parameter int unsigned MAX_DEBT = 8,
  localparam int unsigned DW = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic          clr,
  output logic [DW-1:0] debt
);
  localparam logic [DW-1:0] MAXV = DW'(MAX_DEBT);

  logic [DW-1:0] debt_q, debt_d;

  always_comb begin
    debt_d = debt_q;
    if (clr) begin
      debt_d = '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (debt_q != MAXV) debt_d = debt_q + 1'b1;
        2'b01:   if (debt_q != '0)   debt_d = debt_q - 1'b1;
        default: debt_d = debt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) debt_q <= '0;
    else        debt_q <= debt_d;
  end

  assign debt = debt_q;

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    debt_q <= MAXV);

  assert_dec_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && !clr) |=> (debt_q == $past(debt_q) - 1'b1));

  assert_clear_on_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (debt_q == '0));

endmodule

// File: rtl/sr_sequencer.sv
module sr_sequencer
  import ddr_ref_pkg::*;
#(
  parameter int unsigned TRFC_CYC  = 8,
  parameter int unsigned TXSNR_CYC = 10,
  parameter int unsigned DLL_CYC   = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic debt_nz,
  input  logic ref_issued,
  input  logic sr_enter,
  input  logic sr_exit,
  input  logic clk_stable,
  output logic issue_acc,
  output logic exit_acc,
  output logic in_sr,
  output logic ref_req,
  output logic ref_busy,
  output logic cmd_block,
  output logic cke,
  output logic read_allowed
);
  localparam int unsigned TMAX = (TRFC_CYC > TXSNR_CYC) ? TRFC_CYC : TXSNR_CYC;
  localparam int unsigned TW   = (TMAX > 2) ? $clog2(TMAX) : 1;
  localparam int unsigned LW   = (DLL_CYC > 2) ? $clog2(DLL_CYC) : 1;

  seq_state_e    state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [LW-1:0] dll_q, dll_d;
  logic          dll_busy_q, dll_busy_d;
  logic          cke_q, cke_d;
  logic          rd_q, rd_d;
  logic          enter_acc;

  assign issue_acc = (state_q == ST_IDLE) && debt_nz && ref_issued;
  // refresh takes priority over self refresh entry (R11)
  assign enter_acc = (state_q == ST_IDLE) && sr_enter && !issue_acc;
  assign exit_acc  = (state_q == ST_SR) && sr_exit && clk_stable;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (issue_acc) begin
          state_d = ST_RFC;
          tmr_d   = TW'(TRFC_CYC - 1);
        end else if (enter_acc) begin
          state_d = ST_SR;
        end
      end
      ST_RFC: begin
        if (tmr_q == '0) state_d = ST_IDLE;
        else             tmr_d   = tmr_q - 1'b1;
      end
      ST_SR: begin
        if (exit_acc) begin
          state_d = ST_XSNR;
          tmr_d   = TW'(TXSNR_CYC - 1);
        end
      end
      ST_XSNR: begin
        if (tmr_q == '0) state_d = ST_IDLE;
        else             tmr_d   = tmr_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // DLL relock count runs from the exit edge, independent of the state
  always_comb begin
    dll_d      = dll_q;
    dll_busy_d = dll_busy_q;
    if (exit_acc) begin
      dll_d      = LW'(DLL_CYC - 1);
      dll_busy_d = 1'b1;
    end else if (dll_busy_q) begin
      if (dll_q == '0) dll_busy_d = 1'b0;
      else             dll_d      = dll_q - 1'b1;
    end
  end

  always_comb begin
    cke_d = (state_d != ST_SR);
    rd_d  = ((state_d == ST_IDLE) || (state_d == ST_RFC)) && !dll_busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tmr_q      <= '0;
      dll_q      <= '0;
      dll_busy_q <= 1'b0;
      cke_q      <= 1'b1;
      rd_q       <= 1'b1;
    end else begin
      state_q    <= state_d;
      tmr_q      <= tmr_d;
      dll_q      <= dll_d;
      dll_busy_q <= dll_busy_d;
      cke_q      <= cke_d;
      rd_q       <= rd_d;
    end
  end

  assign in_sr        = (state_q == ST_SR);
  assign ref_busy     = (state_q == ST_RFC);
  assign cmd_block    = (state_q != ST_IDLE);
  assign ref_req      = (state_q == ST_IDLE) && debt_nz;
  assign cke          = cke_q;
  assign read_allowed = rd_q;

  assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_acc |=> (ref_busy && cke));

  assert_cke_high_rfc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> cke);

  assert_enter_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enter_acc |=> (!cke && !read_allowed));

  assert_exit_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sr && !clk_stable) |=> !cke);

  assert_xsnr_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exit_acc |=> (cke && cmd_block && !read_allowed));

  assert_read_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dll_busy_q |-> !read_allowed);

endmodule

// File: rtl/ddr_refresh_sched.sv
module ddr_refresh_sched
  import ddr_ref_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 100000,
  parameter int unsigned MAX_DEBT  = 8,
  parameter int unsigned TRFC_CYC  = 8,
  parameter int unsigned TXSNR_CYC = 10,
  parameter int unsigned DLL_CYC   = 200,
  localparam int unsigned DW       = $clog2(MAX_DEBT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_issued,
  input  logic          sr_enter,
  input  logic          sr_exit,
  input  logic          clk_stable,
  output logic          ref_req,
  output logic          ref_urgent,
  output logic          ref_busy,
  output logic          cmd_block,
  output logic          cke,
  output logic          read_allowed,
  output logic [DW-1:0] debt
);
  localparam int unsigned INTERVAL = refi_cycles(CLK_KHZ);

  logic tick;
  logic issue_acc;
  logic exit_acc;
  logic in_sr;
  logic [DW-1:0] debt_w;

  refi_tick_gen #(.INTERVAL(INTERVAL)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (!in_sr),
    .tick (tick)
  );

  refresh_debt_ctr #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (tick),
    .dec  (issue_acc),
    .clr  (exit_acc),
    .debt (debt_w)
  );

  sr_sequencer #(
    .TRFC_CYC (TRFC_CYC),
    .TXSNR_CYC(TXSNR_CYC),
    .DLL_CYC  (DLL_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .debt_nz     (debt_w != '0),
    .ref_issued  (ref_issued),
    .sr_enter    (sr_enter),
    .sr_exit     (sr_exit),
    .clk_stable  (clk_stable),
    .issue_acc   (issue_acc),
    .exit_acc    (exit_acc),
    .in_sr       (in_sr),
    .ref_req     (ref_req),
    .ref_busy    (ref_busy),
    .cmd_block   (cmd_block),
    .cke         (cke),
    .read_allowed(read_allowed)
  );

  assign ref_urgent = (debt_w == DW'(MAX_DEBT));
  assign debt       = debt_w;

  // R7: no interval tick while the device refreshes itself
  assert_no_tick_in_sr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr |-> !tick);

endmodule

// File: tb/test_ddr_refresh_sched.sv
module test_ddr_refresh_sched;
  localparam int unsigned CLK_KHZ = 2048;  // 16-cycle interval
  localparam int unsigned IV      = 16;
  localparam int unsigned TRFC    = 6;
  localparam int unsigned TXSNR   = 10;
  localparam int unsigned DLL     = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_issued = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0, clk_stable = 1'b0;
  logic ref_req, ref_urgent, ref_busy, cmd_block, cke, read_allowed;
  logic [3:0] debt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ddr_refresh_sched #(
    .CLK_KHZ(CLK_KHZ), .MAX_DEBT(8), .TRFC_CYC(TRFC),
    .TXSNR_CYC(TXSNR), .DLL_CYC(DLL)
  ) i_ddr_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ref_issued(ref_issued), .sr_enter(sr_enter),
    .sr_exit(sr_exit), .clk_stable(clk_stable), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .ref_busy(ref_busy), .cmd_block(cmd_block),
    .cke(cke), .read_allowed(read_allowed), .debt(debt)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ref_issued = 0; sr_enter = 0; sr_exit = 0; clk_stable = 0;
    step(2);
    rst_n = 1'b1;
  endtask

  // pulse an input so exactly one rising edge sees it
  task automatic issue_pulse();
    ref_issued = 1'b1; step(1); ref_issued = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 debt", debt, 0);
    chk("R1 ref_req", ref_req, 0);
    chk("R1 ref_urgent", ref_urgent, 0);
    chk("R1 ref_busy", ref_busy, 0);
    chk("R1 cmd_block", cmd_block, 0);
    chk("R1 cke", cke, 1);
    chk("R1 read_allowed", read_allowed, 1);
  endtask

  task automatic t_tick();
    do_reset();
    step(IV - 1);
    chk("R2 debt before first tick", debt, 0);
    chk("R3 no req at debt 0", ref_req, 0);
    step(1);
    chk("R2 debt after first tick", debt, 1);
    chk("R3 req at debt 1", ref_req, 1);
    step(IV);
    chk("R2 debt after second tick", debt, 2);
  endtask

  task automatic t_saturate();
    do_reset();
    step(8 * IV - 1);
    chk("R4 debt 7", debt, 7);
    chk("R4 not urgent at 7", ref_urgent, 0);
    step(1);
    chk("R4 debt 8", debt, 8);
    chk("R4 urgent at 8", ref_urgent, 1);
    step(2 * IV);
    chk("R4 debt saturates", debt, 8);
    chk("R4 still urgent", ref_urgent, 1);
  endtask

  task automatic t_issue();
    do_reset();
    step(IV);                 // debt 1 after edge 16
    issue_pulse();            // accepted at edge 17
    chk("R5 debt decremented", debt, 0);
    chk("R5 busy", ref_busy, 1);
    chk("R5 cmd_block", cmd_block, 1);
    chk("R5 cke high", cke, 1);
    chk("R3 no req while busy", ref_req, 0);
    step(TRFC - 1);
    chk("R5 busy last cycle", ref_busy, 1);
    step(1);
    chk("R5 busy ends", ref_busy, 0);
    issue_pulse();            // debt 0: ignored
    chk("R6 ignored at debt 0 busy", ref_busy, 0);
    chk("R6 ignored at debt 0 debt", debt, 0);
  endtask

  task automatic t_ignore_busy();
    do_reset();
    step(2 * IV);             // debt 2
    issue_pulse();
    chk("R5 debt 1 after issue", debt, 1);
    issue_pulse();            // during busy: ignored
    chk("R6 debt unchanged during busy", debt, 1);
    step(TRFC - 1);
    chk("R3 req after busy", ref_req, 1);
    chk("R6 debt after busy", debt, 1);
  endtask

  task automatic t_self_refresh();
    do_reset();
    step(IV);                 // debt 1
    sr_enter = 1'b1; step(1); sr_enter = 1'b0;
    chk("R7 cke low", cke, 0);
    chk("R7 read blocked", read_allowed, 0);
    chk("R7 cmd_block", cmd_block, 1);
    step(3 * IV);
    chk("R7 debt frozen", debt, 1);
    sr_exit = 1'b1;
    step(3);
    chk("R8 cke low without clk_stable", cke, 0);
    clk_stable = 1'b1;
    step(1);                  // exit edge X
    sr_exit = 1'b0;
    chk("R9 cke high", cke, 1);
    chk("R9 debt cleared", debt, 0);
    chk("R9 cmd_block in tXSNR", cmd_block, 1);
    step(TXSNR - 1);
    chk("R9 cmd_block last tXSNR cycle", cmd_block, 1);
    step(1);
    chk("R9 cmd_block released", cmd_block, 0);
    chk("R10 read still blocked", read_allowed, 0);
    step(DLL - TXSNR - 1);
    chk("R10 read blocked at X+199", read_allowed, 0);
    step(1);
    chk("R10 read allowed at X+200", read_allowed, 1);
  endtask

  task automatic t_priority();
    do_reset();
    step(IV);
    ref_issued = 1'b1; sr_enter = 1'b1;
    step(1);
    ref_issued = 1'b0; sr_enter = 1'b0;
    chk("R11 refresh wins busy", ref_busy, 1);
    chk("R11 cke stays high", cke, 1);
    step(TRFC);
    chk("R11 sr_enter dropped", cke, 1);
    chk("R11 back idle", cmd_block, 0);
  endtask

  initial begin
    t_reset();
    t_tick();
    t_saturate();
    t_issue();
    t_ignore_busy();
    t_self_refresh();
    t_priority();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule